// File: doc/BRIEF.md
# Sprite Memory DMA Engine

This block copies one whole page of processor address space into a 256-entry sprite attribute memory. A processor write of any value to a fixed trigger address launches the copy, and the written value picks the source page. From the cycle after that write the engine holds the processor halted and drives the memory bus itself. It waits one or two alignment cycles, chosen by the processor cycle parity at the trigger. It then alternates one read from the source page with one write of that byte into sprite memory until all entries are filled. The halt is released in the cycle after the last write.

Any write that reaches the trigger address starts a transfer. This includes the write-back of a read-modify-write instruction. The following real write then lands while the engine is busy and is ignored. A stall input lets an audio-sample fetch take the bus for single cycles. The engine freezes during those cycles and resumes where it stopped.

Top module: `sprite_dma`

## Requirements
- R1: A cycle with `reg_we` high and `reg_addr` equal to `TRIG_ADDR` while idle starts a transfer, and `cpu_halt` and `busy` are high from the next cycle. A write to any other address leaves both low.
- R2: Each source read drives `mem_addr` = {written value, entry index}, meaning the value is shifted left by 8 and the index forms the low byte.
- R3: If `cyc_odd` is high in the trigger cycle, the first halted cycle is the only alignment cycle and the first read is in the second halted cycle. If `cyc_odd` is low, there are two alignment cycles and the first read is in the third halted cycle.
- R4: The copy has exactly 256 read cycles (`mem_rd` high), each followed by one write cycle (`spr_we` high). Reads and writes never share a cycle, and entries are written in order from 0x00 to 0xFF.
- R5: Without stalls, `cpu_halt` is high for exactly 513 cycles (odd trigger) or 514 cycles (even trigger). It falls in the cycle after the final write, and `busy` equals `cpu_halt` throughout.
- R6: In a cycle with `dma_stall` high, neither `mem_rd` nor `spr_we` is asserted and the engine keeps its place. Each stalled cycle adds one cycle to the halt time.
- R7: Trigger writes while busy are ignored. This covers the second write of a read-modify-write pair and a write in the middle of a copy: the source page and the timing are unchanged.
- R8: After reset, `cpu_halt`, `busy`, `mem_rd` and `spr_we` are low.
- R9: `spr_wdata` in each write cycle equals the `mem_rdata` sampled in the most recent read cycle, even when stall cycles lie between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-rate clock, one edge per processor cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Processor register write strobe |
| reg_addr | input | ADDR_W | Processor register write address |
| reg_wdata | input | DATA_W | Processor write data; the page number when at the trigger |
| cyc_odd | input | 1 | High when the current processor cycle is odd |
| dma_stall | input | 1 | Freezes the engine for this cycle (audio-sample fetch) |
| mem_addr | output | ADDR_W | Source read address driven while the engine owns the bus |
| mem_rd | output | 1 | Source read strobe |
| mem_rdata | input | DATA_W | Source read data, valid in the read cycle |
| spr_we | output | 1 | Sprite memory write strobe |
| spr_addr | output | IDX_W | Sprite memory entry index |
| spr_wdata | output | DATA_W | Sprite memory write data |
| cpu_halt | output | 1 | Holds the processor off the bus |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit data, 256 sprite entries and a trigger at 0x4014. Full-length copies therefore reach the 513 and 514 cycle totals and the last entry 0xFF. The source memory is a computed byte function, so every entry of every page has a known value. Random stall patterns, random pages and both parities are mixed with directed read-modify-write double writes, mid-copy writes and off-address writes.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } bus_op_t;

    // Extra alignment cycles beyond the first: one on an even trigger cycle.
    function automatic logic extra_align(input logic odd);
        return !odd;
    endfunction

endpackage

// File: rtl/sdma_trigger.sv
module sdma_trigger
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PG_W = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              start,
    output logic [PG_W-1:0]   page_q
);

    assign start = wr_en && (wr_addr == TRIG_ADDR) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (start) begin
            page_q <= PG_W'(wr_data);
        end
    end

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_odd,
    input  logic             stall,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output bus_op_t          op,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic align_more;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            idx        <= '0;
            align_more <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase      <= PH_ALIGN;
                        idx        <= '0;
                        align_more <= extra_align(start_odd);
                    end
                end
                PH_ALIGN: begin
                    if (!stall) begin
                        if (align_more) align_more <= 1'b0;
                        else            phase <= PH_READ;
                    end
                end
                PH_READ: begin
                    if (!stall) phase <= PH_WRITE;
                end
                PH_WRITE: begin
                    if (!stall) begin
                        if (idx == LAST) begin
                            phase <= PH_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            phase <= PH_READ;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        op.rd = (phase == PH_READ) && !stall;
        op.wr = (phase == PH_WRITE) && !stall;
    end

    assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/sdma_hold.sv
module sdma_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst)          dout <= '0;
        else if (capture) dout <= din;
    end

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SPR_DEPTH = 256,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
    localparam int IDX_W = $clog2(SPR_DEPTH),
    localparam int PG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cyc_odd,
    input  logic              dma_stall,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              spr_we,
    output logic [IDX_W-1:0]  spr_addr,
    output logic [DATA_W-1:0] spr_wdata,
    output logic              cpu_halt,
    output logic              busy
);

    logic             start;
    logic [PG_W-1:0]  page_q;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    bus_op_t          op;
    logic             seq_busy;

    sdma_trigger #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PG_W(PG_W), .TRIG_ADDR(TRIG_ADDR)
    ) u_trig (
        .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .busy(seq_busy), .start(start), .page_q(page_q)
    );

    sdma_seq #(.DEPTH(SPR_DEPTH)) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_odd(cyc_odd),
        .stall(dma_stall), .phase(phase), .idx(idx), .op(op), .busy(seq_busy)
    );

    sdma_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .capture(op.rd), .din(mem_rdata), .dout(spr_wdata)
    );

    assign mem_addr = {page_q, idx};
    assign mem_rd   = op.rd;
    assign spr_we   = op.wr;
    assign spr_addr = idx;
    assign cpu_halt = seq_busy;
    assign busy     = seq_busy;

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
    parameter int ADDR_W = 16,
    parameter int IDX_W = 8,
    parameter int PG_W = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              dma_stall,
    input logic              mem_rd,
    input logic              spr_we,
    input logic [IDX_W-1:0]  spr_addr,
    input logic              busy,
    input logic [PG_W-1:0]   page_q
);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !spr_we));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, spr_we}));

    a_r4_no_back_to_back_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    a_r6_stall_freeze: assert property (@(posedge clk) disable iff (rst)
        dma_stall |-> (!mem_rd && !spr_we));

    a_r6_stall_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && dma_stall) |=> busy);

    a_r1_start: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == TRIG_ADDR && !busy) |=> busy);

    a_r3_align_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!mem_rd && !spr_we));

    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (spr_we && spr_addr == '1) |=> !busy);

    a_r5_hold_mid: assert property (@(posedge clk) disable iff (rst)
        (spr_we && spr_addr != '1) |=> busy);

    a_r7_page_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(page_q));

endmodule

bind sprite_dma sdma_checker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PG_W(PG_W), .TRIG_ADDR(TRIG_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .dma_stall(dma_stall), .mem_rd(mem_rd), .spr_we(spr_we),
    .spr_addr(spr_addr), .busy(busy), .page_q(page_q)
);

// File: tb/sprite_dma_bench.sv
module sprite_dma_bench;

    localparam logic [15:0] TRIG = 16'h4014;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        cyc_odd = 1'b0;
    logic        dma_stall = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        spr_we;
    logic [7:0]  spr_addr;
    logic [7:0]  spr_wdata;
    logic        cpu_halt;
    logic        busy;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29) ^ 8'(a[15:8] + 8'd101) ^ 8'h5A;
    endfunction

    assign mem_rdata = src_byte(mem_addr);

    sprite_dma u_sprite_dma (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cyc_odd(cyc_odd), .dma_stall(dma_stall),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
        .cpu_halt(cpu_halt), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full transfer: pct = stall chance in percent, rmw = second write right after
    // the trigger, mid = an extra trigger write in the middle of the copy.
    task automatic run_xfer(input logic [7:0] page, input bit odd, input int pct,
                            input bit rmw, input bit mid);
        int k = 0, stalls = 0, first_rd = -1, ridx = 0, widx = 0;
        int e_addr = 0, e_order = 0, e_data = 0, e_stall = 0, e_busy = 0;
        bit expect_wr = 1'b0;
        bit st;
        logic [7:0] held = '0;
        int align = odd ? 1 : 2;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = TRIG; reg_wdata = page; cyc_odd = odd;
        forever begin
            @(negedge clk);
            reg_we = (rmw && k == 0) || (mid && k == 100);
            reg_wdata = page ^ 8'hA5;
            cyc_odd = ~cyc_odd;
            st = (pct > 0) && (($urandom % 100) < pct);
            dma_stall = st;
            #1;
            if (!cpu_halt) break;
            k++;
            if (st) stalls++;
            if (busy != cpu_halt) e_busy++;
            if (st && (mem_rd || spr_we)) e_stall++;
            if (mem_rd) begin
                if (first_rd < 0) first_rd = k;
                if (expect_wr) e_order++;
                if (mem_addr != {page, 8'(ridx)}) e_addr++;
                held = src_byte(mem_addr);
                ridx++;
                expect_wr = 1'b1;
            end
            if (spr_we) begin
                if (!expect_wr || spr_addr != 8'(widx)) e_order++;
                if (spr_wdata != held || spr_wdata != src_byte({page, 8'(widx)})) e_data++;
                widx++;
                expect_wr = 1'b0;
            end
            if (k > 5000) break;
        end
        dma_stall = 1'b0;
        reg_we = 1'b0;
        check(e_addr == 0, "R2 source address", e_addr, 0);
        check(e_order == 0 && widx == 256 && ridx == 256, "R4 read/write pairs", widx, 256);
        check(e_data == 0, "R9 written byte", e_data, 0);
        check(e_busy == 0, "R5 busy equals halt", e_busy, 0);
        check(k == 512 + align + stalls, "R5 halt length", k, 512 + align + stalls);
        if (pct > 0) check(e_stall == 0, "R6 stall freeze", e_stall, 0);
        if (pct == 0) check(first_rd == align + 1, "R3 first read cycle", first_rd, align + 1);
        if (rmw || mid) check(e_addr == 0 && k == 512 + align + stalls,
                              "R7 ignored busy write", k, 512 + align + stalls);
        check(!mem_rd && !spr_we && !busy, "R5 released", int'(busy), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!cpu_halt && !busy && !mem_rd && !spr_we, "R8 reset state", int'(cpu_halt), 0);

        // R1: off-address write has no effect
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 16'h4015; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(!cpu_halt && !busy && !mem_rd, "R1 other address ignored", int'(cpu_halt), 0);
            @(negedge clk);
        end

        // R1: trigger starts halt in the next cycle
        reg_we = 1'b1; reg_addr = TRIG; reg_wdata = 8'h03; cyc_odd = 1'b1;
        #1;
        check(!cpu_halt, "R1 no halt in trigger cycle", int'(cpu_halt), 0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check(cpu_halt && busy, "R1 halt after trigger", int'(cpu_halt), 1);
        while (cpu_halt) @(negedge clk);

        run_xfer(8'h02, 1'b1, 0, 1'b0, 1'b0);   // R3 R5 odd
        run_xfer(8'h7F, 1'b0, 0, 1'b0, 1'b0);   // R3 R5 even
        run_xfer(8'hFF, 1'b1, 0, 1'b1, 1'b0);   // R7 read-modify-write pair
        run_xfer(8'h00, 1'b0, 0, 1'b0, 1'b1);   // R7 mid-copy write
        run_xfer(8'h40, 1'b0, 30, 1'b0, 1'b0);  // R6 stalls
        for (int n = 0; n < 5; n++) begin
            run_xfer(8'($urandom), 1'($urandom), int'($urandom % 40),
                     1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule